// File: doc/BRIEF.md
# Radix Page Table Walker

This block translates an effective address by walking a multi-level radix tree held in memory. A walk starts from a root directory base, the number of index bits at the root level, and the total number of translated address bits. At each level the walker picks an entry using a slice of the address and reads it as one 64-bit word through a single-outstanding request/acknowledge memory port. It then either descends into the next directory or stops at a leaf.

The index width is not fixed. Each directory entry carries the index width of the level below it, and the remaining translated size shrinks by that width at every step. Before each read the walker checks two things: that the table base is aligned to the size of its table, and that the level's configuration is one the tree supports. A walk ends with a one-cycle completion pulse. The pulse carries either a translation (real address, page size in bits, leaf entry and its address) or a one-hot fault cause, never both. Permission checks, reference/change updates and nested translation belong to other blocks.

Top module: `radix_walker`

## Requirements
- R1: At every level the entry read address is base + 8 × ((vaddr >> (size − nls)) & (2^nls − 1)). Here size is the remaining translated size and nls is the current index width. Read addresses are 8-byte aligned.
- R2: A table base that is not a multiple of 2^(nls+3) bytes ends the walk with fault cause bit 2 (misaligned base), and no read is made for that level.
- R3: The root level (level 0) is legal only when size = 52 and nls = 13. Any other root configuration ends the walk with fault cause bit 1 (bad configuration) before any read.
- R4: Levels 1 and 2 require nls = 9, level 3 accepts nls = 9 or 5, and level 4 or deeper is always illegal. An illegal level faults with cause bit 1, and no read is made for it.
- R5: A fetched entry whose bit 63 (valid) is clear ends the walk with fault cause bit 0 (no entry).
- R6: A valid entry whose bit 62 (leaf) is clear is a directory. Its bits 4:0 give the next nls, and its bits 55:8 (with bits 7:0 zero) give the next base. The remaining size drops by the current nls, and the next base is checked for alignment (R2) before it is used.
- R7: A valid entry with bit 62 set is a leaf. The page size s is the remaining size minus the current nls. The real address is (entry bits 55:12, shifted to their place) with the low s bits replaced by vaddr's low s bits. The leaf entry and its read address are reported as well.
- R8: done_o is a single-cycle pulse. On a fault, the fault flag is set, exactly one cause bit is set, and the result fields read zero. On success, the fault flag and the cause are zero.
- R9: mem_req_o stays high with a stable address until mem_ack_i, and only one read is outstanding at a time. mem_data_i is taken in the acknowledge cycle.
- R10: start_i is ignored while a walk is in progress (busy_o high). The running walk finishes with its own inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a walk (when idle) |
| vaddr_i | input | 64 | Address to translate |
| root_base_i | input | 56 | Root directory base |
| root_nls_i | input | 5 | Root level index width |
| tree_size_i | input | 6 | Total translated size in bits |
| busy_o | output | 1 | Walk in progress |
| mem_req_o | output | 1 | Memory read request |
| mem_addr_o | output | 56 | Memory read address |
| mem_ack_i | input | 1 | Read data valid |
| mem_data_i | input | 64 | Read data |
| done_o | output | 1 | Walk complete pulse |
| fault_o | output | 1 | Walk ended in fault |
| fault_cause_o | output | 3 | One-hot cause: 0 no entry, 1 bad config, 2 misaligned |
| raddr_o | output | 56 | Translated real address |
| page_bits_o | output | 6 | Page size in bits |
| leaf_pte_o | output | 64 | Leaf entry |
| leaf_addr_o | output | 56 | Address of the leaf entry |

## Verification
The assertions assume the memory raises mem_ack_i only while a request is pending, and for one cycle per request. Without that, the hold-until-acknowledge and single-pulse properties say nothing useful. The bench's memory model acknowledges only a pending request, after a chosen delay of zero to three cycles, and drops the acknowledge the next cycle. Start pulses come at idle, except in the one scenario that tests that a start during a walk is ignored.

// File: rtl/rw_pkg.sv
package rw_pkg;
  localparam int ENT_VALID = 63;
  localparam int ENT_LEAF  = 62;
  localparam int NLB_HI    = 55;
  localparam int NLB_LO    = 8;
  localparam int RPN_HI    = 55;
  localparam int RPN_LO    = 12;
  localparam int NLS_W     = 5;
  localparam int CAUSE_W   = 3;
  localparam int C_NOENT   = 0;
  localparam int C_BADCFG  = 1;
  localparam int C_ALIGN   = 2;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_CHECK,
    ST_FETCH
  } walk_state_e;
endpackage

// File: rtl/rw_index_calc.sv
module rw_index_calc #(
  parameter int VA_W  = 64,
  parameter int PA_W  = 56,
  parameter int SZ_W  = 6,
  parameter int NLS_W = 5
) (
  input  logic [VA_W-1:0]  vaddr_i,
  input  logic [PA_W-1:0]  base_i,
  input  logic [SZ_W-1:0]  size_i,
  input  logic [NLS_W-1:0] nls_i,
  output logic [PA_W-1:0]  ent_addr_o,
  output logic             misaligned_o
);
  logic [SZ_W-1:0] sh;
  logic [63:0]     va_sh, idx_mask, idx, span_mask;

  always_comb begin
    sh        = (size_i >= SZ_W'(nls_i)) ? size_i - SZ_W'(nls_i) : '0;
    va_sh     = 64'(vaddr_i) >> sh;
    idx_mask  = (64'd1 << nls_i) - 64'd1;
    idx       = va_sh & idx_mask;
    span_mask = (64'd1 << (6'(nls_i) + 6'd3)) - 64'd1;
    ent_addr_o   = base_i + PA_W'(idx << 3);
    misaligned_o = |(64'(base_i) & span_mask);
  end
endmodule

// File: rtl/rw_level_check.sv
module rw_level_check #(
  parameter int LVL_W     = 3,
  parameter int SZ_W      = 6,
  parameter int NLS_W     = 5,
  parameter int ROOT_SIZE = 52,
  parameter int ROOT_NLS  = 13,
  parameter int MID_NLS   = 9,
  parameter int ALT_NLS   = 5,
  parameter int LAST_LVL  = 3
) (
  input  logic [LVL_W-1:0] lvl_i,
  input  logic [SZ_W-1:0]  size_i,
  input  logic [NLS_W-1:0] nls_i,
  output logic             legal_o
);
  always_comb begin
    if (lvl_i == LVL_W'(0))
      legal_o = (size_i == SZ_W'(ROOT_SIZE)) && (nls_i == NLS_W'(ROOT_NLS));
    else if (lvl_i < LVL_W'(LAST_LVL))
      legal_o = (nls_i == NLS_W'(MID_NLS));
    else if (lvl_i == LVL_W'(LAST_LVL))
      legal_o = (nls_i == NLS_W'(MID_NLS)) || (nls_i == NLS_W'(ALT_NLS));
    else
      legal_o = 1'b0;
  end
endmodule

// File: rtl/rw_leaf_form.sv
module rw_leaf_form #(
  parameter int VA_W  = 64,
  parameter int PA_W  = 56,
  parameter int SZ_W  = 6,
  parameter int RPN_W = 44,
  parameter int RPN_LO = 12
) (
  input  logic [VA_W-1:0]  vaddr_i,
  input  logic [RPN_W-1:0] rpn_i,
  input  logic [SZ_W-1:0]  page_bits_i,
  output logic [PA_W-1:0]  raddr_o
);
  logic [63:0] off_mask, rpn_full;

  always_comb begin
    off_mask = (64'd1 << page_bits_i) - 64'd1;
    rpn_full = 64'(rpn_i) << RPN_LO;
    raddr_o  = PA_W'((rpn_full & ~off_mask) | (64'(vaddr_i) & off_mask));
  end
endmodule

// File: rtl/radix_walker.sv
module radix_walker
  import rw_pkg::*;
#(
  parameter int VA_W  = 64,
  parameter int PA_W  = 56,
  parameter int SZ_W  = 6,
  parameter int LVL_W = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [VA_W-1:0]    vaddr_i,
  input  logic [PA_W-1:0]    root_base_i,
  input  logic [NLS_W-1:0]   root_nls_i,
  input  logic [SZ_W-1:0]    tree_size_i,
  output logic               busy_o,
  output logic               mem_req_o,
  output logic [PA_W-1:0]    mem_addr_o,
  input  logic               mem_ack_i,
  input  logic [63:0]        mem_data_i,
  output logic               done_o,
  output logic               fault_o,
  output logic [CAUSE_W-1:0] fault_cause_o,
  output logic [PA_W-1:0]    raddr_o,
  output logic [SZ_W-1:0]    page_bits_o,
  output logic [63:0]        leaf_pte_o,
  output logic [PA_W-1:0]    leaf_addr_o
);
  localparam int RPN_W = RPN_HI - RPN_LO + 1;

  walk_state_e        state_q;
  logic [VA_W-1:0]    va_q;
  logic [PA_W-1:0]    base_q, addr_q;
  logic [NLS_W-1:0]   nls_q;
  logic [SZ_W-1:0]    size_q;
  logic [LVL_W-1:0]   lvl_q;

  logic [PA_W-1:0]    ent_addr, leaf_ra;
  logic               misal, legal;
  logic [SZ_W-1:0]    size_nxt;

  logic               fin_fault, fin_ok, descend, issue;
  logic [CAUSE_W-1:0] cause;

  rw_index_calc #(.VA_W(VA_W), .PA_W(PA_W), .SZ_W(SZ_W), .NLS_W(NLS_W)) i_idx (
    .vaddr_i(va_q), .base_i(base_q), .size_i(size_q), .nls_i(nls_q),
    .ent_addr_o(ent_addr), .misaligned_o(misal)
  );

  rw_level_check #(.LVL_W(LVL_W), .SZ_W(SZ_W), .NLS_W(NLS_W)) i_lvl (
    .lvl_i(lvl_q), .size_i(size_q), .nls_i(nls_q), .legal_o(legal)
  );

  assign size_nxt = size_q - SZ_W'(nls_q);

  rw_leaf_form #(.VA_W(VA_W), .PA_W(PA_W), .SZ_W(SZ_W), .RPN_W(RPN_W), .RPN_LO(RPN_LO)) i_leaf (
    .vaddr_i(va_q), .rpn_i(mem_data_i[RPN_HI:RPN_LO]), .page_bits_i(size_nxt),
    .raddr_o(leaf_ra)
  );

  // per-cycle walk decision
  always_comb begin
    fin_fault = 1'b0;
    fin_ok    = 1'b0;
    descend   = 1'b0;
    issue     = 1'b0;
    cause     = '0;
    unique case (state_q)
      ST_CHECK: begin
        if (misal) begin
          fin_fault = 1'b1; cause[C_ALIGN] = 1'b1;
        end else if (!legal) begin
          fin_fault = 1'b1; cause[C_BADCFG] = 1'b1;
        end else begin
          issue = 1'b1;
        end
      end
      ST_FETCH: begin
        if (mem_ack_i) begin
          if (!mem_data_i[ENT_VALID]) begin
            fin_fault = 1'b1; cause[C_NOENT] = 1'b1;
          end else if (mem_data_i[ENT_LEAF]) begin
            fin_ok = 1'b1;
          end else begin
            descend = 1'b1;
          end
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q       <= ST_IDLE;
      va_q          <= '0;
      base_q        <= '0;
      addr_q        <= '0;
      nls_q         <= '0;
      size_q        <= '0;
      lvl_q         <= '0;
      done_o        <= 1'b0;
      fault_o       <= 1'b0;
      fault_cause_o <= '0;
      raddr_o       <= '0;
      page_bits_o   <= '0;
      leaf_pte_o    <= '0;
      leaf_addr_o   <= '0;
    end else begin
      done_o <= 1'b0;
      if (state_q == ST_IDLE && start_i) begin
        va_q    <= vaddr_i;
        base_q  <= root_base_i;
        nls_q   <= root_nls_i;
        size_q  <= tree_size_i;
        lvl_q   <= '0;
        state_q <= ST_CHECK;
      end
      if (issue) begin
        addr_q  <= ent_addr;
        state_q <= ST_FETCH;
      end
      if (descend) begin
        base_q  <= PA_W'({mem_data_i[NLB_HI:NLB_LO], 8'b0});
        nls_q   <= mem_data_i[NLS_W-1:0];
        size_q  <= size_nxt;
        lvl_q   <= lvl_q + LVL_W'(1);
        state_q <= ST_CHECK;
      end
      if (fin_fault || fin_ok) begin
        state_q       <= ST_IDLE;
        done_o        <= 1'b1;
        fault_o       <= fin_fault;
        fault_cause_o <= cause;
        raddr_o       <= fin_ok ? leaf_ra    : '0;
        page_bits_o   <= fin_ok ? size_nxt   : '0;
        leaf_pte_o    <= fin_ok ? mem_data_i : '0;
        leaf_addr_o   <= fin_ok ? addr_q     : '0;
      end
    end
  end

  assign busy_o     = (state_q != ST_IDLE);
  assign mem_req_o  = (state_q == ST_FETCH);
  assign mem_addr_o = addr_q;
endmodule

// File: rtl/rw_walker_chk.sv
module rw_walker_chk #(
  parameter int PA_W    = 56,
  parameter int SZ_W    = 6,
  parameter int CAUSE_W = 3
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               busy_o,
  input logic               mem_req_o,
  input logic [PA_W-1:0]    mem_addr_o,
  input logic               mem_ack_i,
  input logic               done_o,
  input logic               fault_o,
  input logic [CAUSE_W-1:0] fault_cause_o,
  input logic [PA_W-1:0]    raddr_o,
  input logic [SZ_W-1:0]    page_bits_o,
  input logic [63:0]        leaf_pte_o
);
  // R8
  cause_shape_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (fault_o ? ($countones(fault_cause_o) == 1) : (fault_cause_o == '0)));
  // R8
  fault_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && fault_o) |-> (raddr_o == '0 && page_bits_o == '0 && leaf_pte_o == '0));
  // R8
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R9
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o)));
  // R9
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !mem_req_o);
  // R1
  ent_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> (mem_addr_o[2:0] == 3'b000));
  // R7
  leaf_flags_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !fault_o) |-> (leaf_pte_o[63] && leaf_pte_o[62]));
endmodule

bind radix_walker rw_walker_chk #(.PA_W(PA_W), .SZ_W(SZ_W), .CAUSE_W(3)) i_rw_walker_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .busy_o(busy_o), .mem_req_o(mem_req_o),
  .mem_addr_o(mem_addr_o), .mem_ack_i(mem_ack_i), .done_o(done_o), .fault_o(fault_o),
  .fault_cause_o(fault_cause_o), .raddr_o(raddr_o), .page_bits_o(page_bits_o),
  .leaf_pte_o(leaf_pte_o)
);

// File: tb/test_radix_walker.sv
module test_radix_walker;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [63:0] vaddr_i = '0;
  logic [55:0] root_base_i = '0;
  logic [4:0]  root_nls_i = '0;
  logic [5:0]  tree_size_i = '0;
  logic        busy_o, mem_req_o, mem_ack_i, done_o, fault_o;
  logic [55:0] mem_addr_o, raddr_o, leaf_addr_o;
  logic [63:0] mem_data_i, leaf_pte_o;
  logic [2:0]  fault_cause_o;
  logic [5:0]  page_bits_o;

  radix_walker i_radix_walker (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  int n_vec = 0;
  int n_bad = 0;
  int ack_delay = 0;
  int wait_cnt = 0;
  logic [63:0] mem [logic [55:0]];
  logic [55:0] rd_log [$];

  logic        g_fault;
  logic [2:0]  g_cause;
  logic [55:0] g_ra, g_la;
  logic [5:0]  g_pg;
  logic [63:0] g_pte;

  localparam logic [55:0] ROOT = 56'h01_0000;
  localparam logic [55:0] B1   = 56'h02_0000;
  localparam logic [55:0] B2   = 56'h03_0000;
  localparam logic [55:0] B3   = 56'h04_0000;
  localparam logic [63:0] VA   = 64'h0000_1234_5678_9ABC;
  localparam logic [55:0] PA   = 56'h00_00AB_CDE0_0000;

  // memory model: acknowledges a pending request after ack_delay cycles
  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_ack_i  <= 1'b0;
      mem_data_i <= '0;
      wait_cnt   <= 0;
    end else if (mem_ack_i) begin
      mem_ack_i <= 1'b0;
    end else if (mem_req_o) begin
      if (wait_cnt >= ack_delay) begin
        mem_ack_i  <= 1'b1;
        mem_data_i <= mem.exists(mem_addr_o) ? mem[mem_addr_o] : 64'd0;
        rd_log.push_back(mem_addr_o);
        wait_cnt   <= 0;
      end else begin
        wait_cnt <= wait_cnt + 1;
      end
    end
  end

  function automatic logic [55:0] ent(logic [55:0] base, int sh, int n);
    logic [63:0] ix = (VA >> sh) & ((64'd1 << n) - 64'd1);
    return base + 56'(ix * 8);
  endfunction

  function automatic logic [63:0] dir(logic [55:0] base, int n);
    return 64'h8000_0000_0000_0000 | (64'(base) & 64'h00FF_FFFF_FFFF_FF00) | 64'(n);
  endfunction

  function automatic logic [63:0] leaf(logic [55:0] pa);
    return 64'hC000_0000_0000_0000 | (64'(pa) & 64'h00FF_FFFF_FFFF_F000);
  endfunction

  function automatic logic [55:0] xlat(logic [55:0] pa, int s);
    logic [63:0] m = (64'd1 << s) - 64'd1;
    return 56'(((64'(pa) & 64'h00FF_FFFF_FFFF_F000) & ~m) | (VA & m));
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_walk(logic [63:0] va, logic [55:0] rb, logic [4:0] nls, logic [5:0] sz);
    bit seen = 0;
    rd_log.delete();
    @(negedge clk_i);
    vaddr_i = va; root_base_i = rb; root_nls_i = nls; tree_size_i = sz; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    for (int i = 0; i < 200 && !seen; i++) begin
      if (done_o) begin
        seen = 1;
        g_fault = fault_o; g_cause = fault_cause_o; g_ra = raddr_o;
        g_pg = page_bits_o; g_pte = leaf_pte_o; g_la = leaf_addr_o;
      end else @(negedge clk_i);
    end
    chk("R8 done seen", 64'(seen), 64'd1);
  endtask

  task automatic build_4k();
    mem.delete();
    mem[ent(ROOT, 39, 13)] = dir(B1, 9);
    mem[ent(B1, 30, 9)]    = dir(B2, 9);
    mem[ent(B2, 21, 9)]    = dir(B3, 9);
    mem[ent(B3, 12, 9)]    = leaf(PA);
  endtask

  task automatic t_reset();
    chk("R8 reset done", 64'(done_o), 64'd0);
    chk("R9 reset req", 64'(mem_req_o), 64'd0);
    chk("R10 reset busy", 64'(busy_o), 64'd0);
  endtask

  task automatic t_walk_4k();
    build_4k();
    ack_delay = 2;
    run_walk(VA, ROOT, 5'd13, 6'd52);
    chk("R7 fault", 64'(g_fault), 64'd0);
    chk("R8 cause zero", 64'(g_cause), 64'd0);
    chk("R7 raddr 4k", 64'(g_ra), 64'(xlat(PA, 12)));
    chk("R7 page bits", 64'(g_pg), 64'd12);
    chk("R7 leaf pte", g_pte, leaf(PA));
    chk("R7 leaf addr", 64'(g_la), 64'(ent(B3, 12, 9)));
    chk("R9 read count", 64'(rd_log.size()), 64'd4);
    if (rd_log.size() == 4) begin
      chk("R1 read0", 64'(rd_log[0]), 64'(ent(ROOT, 39, 13)));
      chk("R1 read1", 64'(rd_log[1]), 64'(ent(B1, 30, 9)));
      chk("R6 read2", 64'(rd_log[2]), 64'(ent(B2, 21, 9)));
      chk("R6 read3", 64'(rd_log[3]), 64'(ent(B3, 12, 9)));
    end
  endtask

  task automatic t_leaf_2m();
    mem.delete();
    ack_delay = 0;
    mem[ent(ROOT, 39, 13)] = dir(B1, 9);
    mem[ent(B1, 30, 9)]    = dir(B2, 9);
    mem[ent(B2, 21, 9)]    = leaf(56'h00_0077_7700_0000);
    run_walk(VA, ROOT, 5'd13, 6'd52);
    chk("R7 2m fault", 64'(g_fault), 64'd0);
    chk("R7 2m page", 64'(g_pg), 64'd21);
    chk("R7 2m raddr", 64'(g_ra), 64'(xlat(56'h00_0077_7700_0000, 21)));
  endtask

  task automatic t_leaf_root();
    mem.delete();
    ack_delay = 1;
    mem[ent(ROOT, 39, 13)] = leaf(56'h00_5500_0000_0000);
    run_walk(VA, ROOT, 5'd13, 6'd52);
    chk("R7 root leaf page", 64'(g_pg), 64'd39);
    chk("R7 root leaf raddr", 64'(g_ra), 64'(xlat(56'h00_5500_0000_0000, 39)));
  endtask

  task automatic t_nls5();
    mem.delete();
    ack_delay = 3;
    mem[ent(ROOT, 39, 13)]   = dir(B1, 9);
    mem[ent(B1, 30, 9)]      = dir(B2, 9);
    mem[ent(B2, 21, 9)]      = dir(56'h05_0100, 5);
    mem[ent(56'h05_0100, 16, 5)] = leaf(PA);
    run_walk(VA, ROOT, 5'd13, 6'd52);
    chk("R4 nls5 fault", 64'(g_fault), 64'd0);
    chk("R4 nls5 page", 64'(g_pg), 64'd16);
    chk("R4 nls5 raddr", 64'(g_ra), 64'(xlat(PA, 16)));
    chk("R4 nls5 leaf addr", 64'(g_la), 64'(ent(56'h05_0100, 16, 5)));
  endtask

  task automatic t_invalid();
    mem.delete();
    ack_delay = 0;
    mem[ent(ROOT, 39, 13)] = dir(B1, 9);
    run_walk(VA, ROOT, 5'd13, 6'd52);
    chk("R5 fault", 64'(g_fault), 64'd1);
    chk("R5 cause", 64'(g_cause), 64'b001);
    chk("R8 raddr zero", 64'(g_ra), 64'd0);
    chk("R5 reads", 64'(rd_log.size()), 64'd2);
  endtask

  task automatic t_root_misaligned();
    build_4k();
    run_walk(VA, ROOT + 56'h8, 5'd13, 6'd52);
    chk("R2 cause", 64'(g_cause), 64'b100);
    chk("R2 no read", 64'(rd_log.size()), 64'd0);
  endtask

  task automatic t_root_badcfg();
    build_4k();
    run_walk(VA, ROOT, 5'd12, 6'd52);
    chk("R3 nls cause", 64'(g_cause), 64'b010);
    chk("R3 nls no read", 64'(rd_log.size()), 64'd0);
    run_walk(VA, ROOT, 5'd13, 6'd48);
    chk("R3 size cause", 64'(g_cause), 64'b010);
    chk("R3 size no read", 64'(rd_log.size()), 64'd0);
  endtask

  task automatic t_mid_badcfg();
    mem.delete();
    mem[ent(ROOT, 39, 13)] = dir(B1, 5);
    run_walk(VA, ROOT, 5'd13, 6'd52);
    chk("R4 level1 nls5 cause", 64'(g_cause), 64'b010);
    chk("R4 level1 reads", 64'(rd_log.size()), 64'd1);
  endtask

  task automatic t_level4();
    build_4k();
    mem[ent(B3, 12, 9)] = dir(56'h06_0000, 9);
    run_walk(VA, ROOT, 5'd13, 6'd52);
    chk("R4 level4 cause", 64'(g_cause), 64'b010);
    chk("R4 level4 reads", 64'(rd_log.size()), 64'd4);
  endtask

  task automatic t_next_misaligned();
    mem.delete();
    mem[ent(ROOT, 39, 13)] = dir(56'h02_0800, 9);
    run_walk(VA, ROOT, 5'd13, 6'd52);
    chk("R6 next base cause", 64'(g_cause), 64'b100);
    chk("R6 next base reads", 64'(rd_log.size()), 64'd1);
  endtask

  task automatic t_start_busy();
    bit seen = 0;
    build_4k();
    ack_delay = 1;
    rd_log.delete();
    @(negedge clk_i);
    vaddr_i = VA; root_base_i = ROOT; root_nls_i = 5'd13; tree_size_i = 6'd52; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    repeat (3) @(negedge clk_i);
    chk("R10 busy mid walk", 64'(busy_o), 64'd1);
    vaddr_i = 64'hFFFF; root_base_i = ROOT + 56'h8; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    for (int i = 0; i < 200 && !seen; i++) begin
      if (done_o) begin
        seen = 1;
        chk("R10 fault", 64'(fault_o), 64'd0);
        chk("R10 raddr", 64'(raddr_o), 64'(xlat(PA, 12)));
      end else @(negedge clk_i);
    end
    chk("R10 done seen", 64'(seen), 64'd1);
    @(negedge clk_i);
    chk("R10 idle after", 64'(busy_o), 64'd0);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk_i);
    n_bad++;
    $display("FAIL R9 watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_walk_4k();
    t_leaf_2m();
    t_leaf_root();
    t_nls5();
    t_invalid();
    t_root_misaligned();
    t_root_badcfg();
    t_mid_badcfg();
    t_level4();
    t_next_misaligned();
    t_start_busy();
    repeat (2) @(negedge clk_i);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule